// File: doc/BRIEF.md
# Pixel Hit Time-Stamp Capture Array

This block is the digital tier of a small-pitch pixel matrix. Each pixel cell watches its own hit strobe during a detection phase. On the first hit it stores the Gray-coded time-stamp value currently on a shared bus. On any later hit it only raises a second-hit flag, so the first arrival time is kept. A pixel therefore carries six bits: a flag followed by a five-bit stamp.

When detection ends, the same storage flip-flops are switched by a test-enable mux into one serial scan chain. That chain runs through the matrix in serpentine order, and the whole matrix is shifted out through a single pin, one bit per enabled clock. Zeros fill the chain behind the data, so the matrix is empty after a full readout. A test input injects an emulated hit into every pixel on a clock edge, which lets the digital tier be exercised without the analog front end.

A four-state controller sequences the block. In IDLE nothing is captured. `start_det` moves it to CLEAR, which holds for one cycle and empties every cell. It then goes to DETECT, where hits are accepted; `start_det` here takes it back to CLEAR. `start_rd` moves it from IDLE or DETECT to SHIFT. SHIFT returns to IDLE after the last chain bit has been shifted.

Top module: `pix_ts_array`

## Requirements
- R1: After reset `ser_valid`, `detecting` and `ser_out` are 0 and every pixel reads as empty, meaning all six bits are 0.
- R2: A `start_det` pulse seen in IDLE or DETECT gives one CLEAR cycle with `detecting` low. `detecting` is then high from the following cycle.
- R3: The first hit on a pixel while `detecting` is high stores the `ts_gray` value present at that clock edge. The flag stays 0.
- R4: A second or later hit on a pixel during the same detection phase sets its flag to 1 and leaves its stored stamp unchanged.
- R5: `inj_i` high at a clock edge while `detecting` is high acts as a hit on every pixel at once.
- R6: Readout order: pixel p = row*NUM_COLS + col maps to `hit_i[p]`. Pixels leave by row, starting with row 0. Even rows run col 0 upward and odd rows run from the top col down. Each pixel sends its flag first and then its stamp MSB first.
- R7: In SHIFT, `ser_valid` is 1 and `ser_out` moves to the next bit only after a clock edge with `shift_en` high. After NUM_ROWS*NUM_COLS*6 such shifts the block returns to IDLE with `ser_valid` 0.
- R8: Hits and `inj_i` outside DETECT, whether in IDLE or SHIFT, change no stored data.
- R9: `start_det` during DETECT discards every captured stamp and flag.
- R10: After a complete readout every pixel is empty. A readout started from IDLE then streams only zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_det | input | 1 | Clear the matrix and begin a detection phase |
| start_rd | input | 1 | Begin serial readout |
| ts_gray | input | TS_W | Broadcast Gray-coded time stamp |
| hit_i | input | NUM_ROWS*NUM_COLS | Per-pixel hit strobes, index row*NUM_COLS+col |
| inj_i | input | 1 | Emulated hit into all pixels |
| shift_en | input | 1 | Advance the scan chain by one bit |
| ser_out | output | 1 | Serial data bit |
| ser_valid | output | 1 | High while in SHIFT |
| detecting | output | 1 | High while in DETECT |

## Verification
Stored state is only visible through the serial stream, so a wrong cell shows up as a mismatch at that pixel's bit offset in the next readout. That offset is at most NUM_ROWS*NUM_COLS*6 enabled shifts after SHIFT is entered. A lost or doubled shift shows up as every later bit being shifted by one position. A wrong exit count shows as `ser_valid` staying high, or falling, one shift off. Faults in clear or ignore behaviour only appear in the readout that follows, which is why the bench reads the matrix out again from IDLE.

// File: rtl/pts_pkg.sv
package pts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLEAR  = 2'd1,
        ST_DETECT = 2'd2,
        ST_SHIFT  = 2'd3
    } pts_state_e;
endpackage

// File: rtl/ts_cell.sv
module ts_cell #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            det_en,
    input  logic            hit,
    input  logic [TS_W-1:0] ts_in,
    input  logic            scan_en,
    input  logic            scan_in,
    output logic            scan_out
);
    localparam int WW = TS_W + 1;

    logic [WW-1:0] word_q, word_d, func_d;
    logic          seen_q, seen_d;

    // functional path: first hit loads stamp, later hits set flag
    always_comb begin
        func_d = word_q;
        seen_d = seen_q;
        if (clr) begin
            func_d = '0;
            seen_d = 1'b0;
        end else if (det_en && hit) begin
            if (!seen_q) begin
                func_d[TS_W-1:0] = ts_in;
                seen_d           = 1'b1;
            end else begin
                func_d[TS_W] = 1'b1;
            end
        end
    end

    // test-enable mux in front of the storage flops
    always_comb begin
        word_d = scan_en ? {word_q[WW-2:0], scan_in} : func_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            seen_q <= 1'b0;
        end else begin
            word_q <= word_d;
            seen_q <= scan_en ? 1'b0 : seen_d;
        end
    end

    assign scan_out = word_q[WW-1];

    p_ts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !clr && !scan_en) |=> $stable(word_q[TS_W-1:0]));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q[TS_W] && !clr && !scan_en) |=> word_q[TS_W]);

    p_ignore_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en && !clr && !scan_en) |=> $stable(word_q));

    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !scan_en) |=> (word_q == '0 && !seen_q));
endmodule

// File: rtl/ts_seq_ctrl.sv
module ts_seq_ctrl
    import pts_pkg::*;
#(
    parameter int NB = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic start_rd,
    input  logic shift_en,
    output logic clr_o,
    output logic det_en_o,
    output logic shift_o,
    output logic valid_o
);
    localparam int CW = $clog2(NB + 1);

    pts_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_shift;

    assign last_shift = (state_q == ST_SHIFT) && shift_en && (cnt_q == CW'(NB - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_det)     state_d = ST_CLEAR;
                else if (start_rd) state_d = ST_SHIFT;
            end
            ST_CLEAR:  state_d = ST_DETECT;
            ST_DETECT: begin
                if (start_det)     state_d = ST_CLEAR;
                else if (start_rd) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (last_shift)    state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        clr_o    = 1'b0;
        det_en_o = 1'b0;
        shift_o  = 1'b0;
        valid_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CLEAR:  clr_o = 1'b1;
            ST_DETECT: det_en_o = 1'b1;
            ST_SHIFT: begin
                valid_o = 1'b1;
                shift_o = shift_en;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (state_q != ST_SHIFT || last_shift) cnt_q <= '0;
        else if (shift_en)                       cnt_q <= cnt_q + 1'b1;
    end

    p_clear_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (state_q == ST_DETECT));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(NB));

    p_hold_no_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !shift_en) |=> (state_q == ST_SHIFT && $stable(cnt_q)));
endmodule

// File: rtl/pix_ts_array.sv
module pix_ts_array #(
    parameter int NUM_COLS = 4,
    parameter int NUM_ROWS = 3,
    parameter int TS_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_det,
    input  logic                         start_rd,
    input  logic [TS_W-1:0]              ts_gray,
    input  logic [NUM_ROWS*NUM_COLS-1:0] hit_i,
    input  logic                         inj_i,
    input  logic                         shift_en,
    output logic                         ser_out,
    output logic                         ser_valid,
    output logic                         detecting
);
    localparam int NPIX = NUM_ROWS * NUM_COLS;
    localparam int NB   = NPIX * (TS_W + 1);

    logic          clr, det_en, shift_go;
    logic [NPIX:0] chain;

    ts_seq_ctrl #(.NB(NB)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_det(start_det),
        .start_rd (start_rd),
        .shift_en (shift_en),
        .clr_o    (clr),
        .det_en_o (det_en),
        .shift_o  (shift_go),
        .valid_o  (ser_valid)
    );

    assign chain[NPIX] = 1'b0;

    // cell s sits at serpentine position s; position 0 drives the pin
    for (genvar s = 0; s < NPIX; s++) begin : g_seq
        localparam int ROW = s / NUM_COLS;
        localparam int K   = s % NUM_COLS;
        localparam int COL = (ROW % 2 == 0) ? K : (NUM_COLS - 1 - K);
        localparam int PIX = ROW * NUM_COLS + COL;

        ts_cell #(.TS_W(TS_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .det_en  (det_en),
            .hit     (hit_i[PIX] | inj_i),
            .ts_in   (ts_gray),
            .scan_en (shift_go),
            .scan_in (chain[s+1]),
            .scan_out(chain[s])
        );
    end

    assign ser_out   = chain[0];
    assign detecting = det_en;

    p_modes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_valid && detecting));
endmodule

// File: tb/pix_ts_array_tb.sv
module pix_ts_array_tb;
    localparam int NC   = 4;
    localparam int NR   = 3;
    localparam int TW   = 5;
    localparam int NPIX = NC * NR;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_det = 1'b0;
    logic            start_rd = 1'b0;
    logic [TW-1:0]   ts_gray = '0;
    logic [NPIX-1:0] hit_i = '0;
    logic            inj_i = 1'b0;
    logic            shift_en = 1'b0;
    logic            ser_out, ser_valid, detecting;

    int n_cmp = 0;
    int n_bad = 0;

    logic          m_seen [NPIX];
    logic          m_flag [NPIX];
    logic [TW-1:0] m_ts   [NPIX];
    logic          m_det = 1'b0;
    logic          exp_q [$];

    always #10 clk = ~clk;

    pix_ts_array #(.NUM_COLS(NC), .NUM_ROWS(NR), .TS_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .start_rd(start_rd),
        .ts_gray(ts_gray), .hit_i(hit_i), .inj_i(inj_i), .shift_en(shift_en),
        .ser_out(ser_out), .ser_valid(ser_valid), .detecting(detecting)
    );

    function automatic logic [TW-1:0] gray(input int b);
        logic [TW-1:0] v;
        v = TW'(b);
        return v ^ (v >> 1);
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NPIX; p++) begin
            m_seen[p] = 1'b0; m_flag[p] = 1'b0; m_ts[p] = '0;
        end
    endtask

    task automatic do_start_det(input string req);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        chk(detecting, 1'b0, req);
        @(negedge clk);
        chk(detecting, 1'b1, req);
        model_clear();
        m_det = 1'b1;
    endtask

    task automatic drive_hit(input logic [NPIX-1:0] pat, input int tsb, input logic inj);
        hit_i = pat; ts_gray = gray(tsb); inj_i = inj;
        if (m_det) begin
            for (int p = 0; p < NPIX; p++) begin
                if (pat[p] || inj) begin
                    if (!m_seen[p]) begin m_seen[p] = 1'b1; m_ts[p] = gray(tsb); end
                    else m_flag[p] = 1'b1;
                end
            end
        end
        @(negedge clk);
        hit_i = '0; inj_i = 1'b0;
    endtask

    // driver side: push expected bits in serpentine order (R6)
    task automatic push_expected();
        for (int s = 0; s < NPIX; s++) begin
            int row, k, col, p;
            row = s / NC; k = s % NC;
            col = (row % 2 == 0) ? k : NC - 1 - k;
            p = row * NC + col;
            exp_q.push_back(m_flag[p]);
            for (int b = TW - 1; b >= 0; b--) exp_q.push_back(m_ts[p][b]);
        end
    endtask

    // monitor side: compare each bit, stall on some cycles, poke hits (R8)
    task automatic readout(input string req);
        int i;
        push_expected();
        start_rd = 1'b1;
        @(negedge clk);
        start_rd = 1'b0;
        m_det = 1'b0;
        chk(ser_valid, 1'b1, "R7");
        i = 0;
        while (exp_q.size() > 0) begin
            logic en;
            chk(ser_out, exp_q[0], req);
            en = (i % 4 != 2);
            shift_en = en;
            hit_i = (i == 9) ? '1 : '0;
            inj_i = (i == 13);
            if (en) void'(exp_q.pop_front());
            i++;
            @(negedge clk);
        end
        shift_en = 1'b0; hit_i = '0; inj_i = 1'b0;
        chk(ser_valid, 1'b0, "R7");
        model_clear();
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(ser_valid, 1'b0, "R1");
        chk(detecting, 1'b0, "R1");
        chk(ser_out, 1'b0, "R1");
        readout("R1");

        do_start_det("R2");
        drive_hit(NPIX'(1) << 0, 3, 1'b0);                       // R3
        drive_hit(NPIX'(1) << 5, 7, 1'b0);
        drive_hit(NPIX'(1) << 0, 9, 1'b0);                       // R4
        drive_hit((NPIX'(1) << 5) | (NPIX'(1) << 6), 12, 1'b0);
        drive_hit(NPIX'(1) << 11, 31, 1'b0);
        drive_hit(NPIX'(1) << 4, 18, 1'b0);
        readout("R6");

        drive_hit('1, 22, 1'b0);                                 // R8 idle
        drive_hit('0, 23, 1'b1);
        readout("R10");

        do_start_det("R2");
        drive_hit('0, 2, 1'b1);                                  // R5
        drive_hit(NPIX'(1) << 3, 6, 1'b0);
        readout("R5");

        do_start_det("R2");
        drive_hit((NPIX'(1) << 1) | (NPIX'(1) << 2), 14, 1'b0);
        do_start_det("R9");
        drive_hit(NPIX'(1) << 7, 20, 1'b0);
        readout("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule